// File: doc/BRIEF.md
# Transmit Start-Threshold FIFO

This block is a small speed-matching store between a DMA fetch engine and a transmitter that consumes data at a fixed rate. The fetch side writes 64-bit words, often two 4-word cache blocks back to back. The transmit side asks for one word on each drain tick. A packet is held back until enough of it is buffered: either the programmed threshold in words is present, or its last word has arrived. Because the drain rate is constant, the threshold sets how much memory read latency the store can cover.

Once a packet has started it must never stall. If a drain tick finds the store empty in the middle of a packet, the block reports an underflow by sending a one-cycle abort marker to the transmitter. It then discards whatever is left of that packet up to and including its last word, so the next packet starts clean. The fetch engine reads the free-space count to decide whether a block or a pair of blocks fits.

Top module: `tx_thresh_fifo`

## Requirements
- R1: After reset, tx_valid and tx_abort are 0 and fill_space equals the depth (32 words).
- R2: No word of a packet is presented until the stored word count reaches cfg_thresh, counted in 64-bit words. A cfg_thresh of 0 acts as 1.
- R3: A packet shorter than cfg_thresh starts once its last word, written with wr_eop=1, is stored.
- R4: After start, each cycle with drain_tick=1 yields exactly one word on the following cycle (tx_valid=1). Words come out in write order, and tx_eop=1 marks the last word of the packet.
- R5: Writes on consecutive cycles, including two 4-word blocks back to back, are all accepted while space remains.
- R6: A write while fill_space is 0 is dropped and the stored level never exceeds the depth. fill_space always equals the depth minus the stored word count.
- R7: A drain_tick during a started packet that finds the store empty produces a one-cycle tx_abort on the next cycle, with tx_valid=0.
- R8: After an abort, the remaining words of that packet, through its wr_eop word, are discarded without tx_valid. The following packet is then delivered normally.
- R9: A cfg_thresh above the depth means no start on level alone, so the block waits for a stored wr_eop word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_thresh | input | 6 | Start threshold in 64-bit words (quasi-static) |
| wr_en | input | 1 | Write one word from the fetch side |
| wr_data | input | 64 | Word to store |
| wr_eop | input | 1 | Word is the last of its packet |
| fill_space | output | 6 | Free word slots |
| drain_tick | input | 1 | Transmitter consumes one word this cycle |
| tx_valid | output | 1 | tx_data holds a packet word |
| tx_data | output | 64 | Word to the transmitter |
| tx_eop | output | 1 | tx_data is the last word of the packet |
| tx_abort | output | 1 | Underflow marker: current packet aborted |

## Verification
The checker tests several properties on every cycle. A word only appears the cycle after a drain tick. A packet only enters sending when the level reaches the effective threshold or a stored end marker exists. An empty store on a tick in sending raises the abort on the next cycle. Nothing is presented while flushing, abort and valid never coincide, and the level never passes the depth. Only the bench scenarios can show the rest: that data order and end markers survive end to end, that short packets and above-depth thresholds start on the end marker, that writes into a full store are lost, and that a flushed packet leaves the following packet intact.

// File: rtl/tx_thresh_fifo_pkg.sv
package tx_thresh_fifo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_FLUSH = 2'd2
  } txf_state_e;
endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_eop,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_eop,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  eop_cnt,
  output logic              empty
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W:0]    mem [DEPTH];
  logic [AW-1:0]      wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]      rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]   level_q, level_d;
  logic [CNT_W-1:0]   eop_q, eop_d;
  logic               push_ok, pop_ok;
  logic               eop_in, eop_out;

  assign push_ok = push && (level_q != DEPTH_C);
  assign pop_ok  = pop && (level_q != '0);
  assign eop_in  = push_ok && push_eop;
  assign eop_out = pop_ok && mem[rd_ptr_q][DATA_W];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    eop_d    = eop_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + AW'(1);
    if (pop_ok)  rd_ptr_d = rd_ptr_q + AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   level_d = level_q + CNT_W'(1);
      2'b01:   level_d = level_q - CNT_W'(1);
      default: level_d = level_q;
    endcase
    case ({eop_in, eop_out})
      2'b10:   eop_d = eop_q + CNT_W'(1);
      2'b01:   eop_d = eop_q - CNT_W'(1);
      default: eop_d = eop_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      eop_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      eop_q    <= eop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= {push_eop, push_data};
  end

  assign head_data = mem[rd_ptr_q][DATA_W-1:0];
  assign head_eop  = mem[rd_ptr_q][DATA_W];
  assign level     = level_q;
  assign eop_cnt   = eop_q;
  assign empty     = (level_q == '0);
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import tx_thresh_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] eop_cnt,
  input  logic             empty,
  input  logic             head_eop,
  input  logic             drain_tick,
  output logic             pop,
  output logic             fire,
  output logic             abort_req,
  output txf_state_e       state
);
  txf_state_e       st_q, st_d;
  logic [CNT_W-1:0] thr_eff;
  logic             start_ok;

  assign thr_eff  = (thresh == '0) ? CNT_W'(1) : thresh;
  assign start_ok = (level >= thr_eff) || (eop_cnt != '0);

  always_comb begin
    st_d      = st_q;
    pop       = 1'b0;
    fire      = 1'b0;
    abort_req = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) st_d = ST_SEND;
      end
      ST_SEND: begin
        if (drain_tick) begin
          if (!empty) begin
            pop  = 1'b1;
            fire = 1'b1;
            if (head_eop) st_d = ST_IDLE;
          end else begin
            abort_req = 1'b1;
            st_d      = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        if (!empty) begin
          pop = 1'b1;
          if (head_eop) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/txf_out.sv
module txf_out #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              abort_req,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_eop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_eop,
  output logic              tx_abort
);
  logic              valid_q, eop_q, abort_q;
  logic              eop_d;
  logic [DATA_W-1:0] data_q;

  assign eop_d = fire && head_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      eop_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      valid_q <= fire;
      eop_q   <= eop_d;
      abort_q <= abort_req;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) data_q <= head_data;
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;
  assign tx_eop   = eop_q;
  assign tx_abort = abort_q;
endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo
  import tx_thresh_fifo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  output logic [CNT_W-1:0]  fill_space,
  input  logic              drain_tick,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_eop,
  output logic              tx_abort
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic              rst_n_s;
  logic              pop, fire, abort_req, empty, head_eop;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  level, eop_cnt;
  txf_state_e        state;

  txf_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (wr_en),
    .push_data (wr_data),
    .push_eop  (wr_eop),
    .pop       (pop),
    .head_data (head_data),
    .head_eop  (head_eop),
    .level     (level),
    .eop_cnt   (eop_cnt),
    .empty     (empty)
  );

  txf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .thresh     (cfg_thresh),
    .level      (level),
    .eop_cnt    (eop_cnt),
    .empty      (empty),
    .head_eop   (head_eop),
    .drain_tick (drain_tick),
    .pop        (pop),
    .fire       (fire),
    .abort_req  (abort_req),
    .state      (state)
  );

  txf_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fire      (fire),
    .abort_req (abort_req),
    .head_data (head_data),
    .head_eop  (head_eop),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_eop    (tx_eop),
    .tx_abort  (tx_abort)
  );

  assign fill_space = DEPTH_C - level;
endmodule

// File: rtl/tx_thresh_fifo_chk.sv
module tx_thresh_fifo_chk
  import tx_thresh_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drain_tick,
  input logic             tx_valid,
  input logic             tx_eop,
  input logic             tx_abort,
  input txf_state_e       state,
  input logic [CNT_W-1:0] level,
  input logic [CNT_W-1:0] eop_cnt,
  input logic [CNT_W-1:0] thresh
);
  logic [CNT_W-1:0] chk_thr;
  assign chk_thr = (thresh == '0) ? CNT_W'(1) : thresh;

  // R2, R3, R9: sending begins only with threshold reached or an end marker stored
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && $past(state) == ST_IDLE) |->
      $past(level >= chk_thr || eop_cnt != '0));

  // R4: a word is presented only the cycle after a drain tick
  assert_word_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(drain_tick));

  // R4: end marker only travels with a word
  assert_eop_with_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop |-> tx_valid);

  // R6: stored level never passes the depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  // R7: empty store on a tick while sending gives an abort next cycle
  assert_abort_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && drain_tick && level == '0) |=> (tx_abort && !tx_valid));

  // R7: abort and word never together
  assert_abort_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_abort && tx_valid));

  // R8: flushing presents nothing
  assert_flush_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH) |=> !tx_valid);
endmodule

bind tx_thresh_fifo tx_thresh_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .drain_tick (drain_tick),
  .tx_valid   (tx_valid),
  .tx_eop     (tx_eop),
  .tx_abort   (tx_abort),
  .state      (state),
  .level      (level),
  .eop_cnt    (eop_cnt),
  .thresh     (cfg_thresh)
);

// File: tb/tx_thresh_fifo_bench.sv
module tx_thresh_fifo_bench;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 32;
  localparam int CNT_W  = 6;
  localparam int ROWS   = 7;
  // columns: threshold, packet length, words before long pause, abort expected
  localparam int TBL [ROWS][4] = '{
    '{8, 16, 16, 0},
    '{20, 6, 6, 0},
    '{1, 1, 1, 0},
    '{32, 32, 32, 0},
    '{3, 10, 4, 1},
    '{0, 5, 2, 1},
    '{4, 12, 12, 0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CNT_W-1:0]  cfg_thresh;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              wr_eop;
  logic [CNT_W-1:0]  fill_space;
  logic              drain_tick;
  logic              tx_valid;
  logic [DATA_W-1:0] tx_data;
  logic              tx_eop;
  logic              tx_abort;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int first_wr = -1;
  int rx_n = 0;
  int abort_n = 0;
  int tick_err = 0;
  logic [DATA_W-1:0] rx_data [64];
  logic              rx_eop  [64];
  logic              last_tick = 1'b0;

  always #10 clk = ~clk;

  tx_thresh_fifo u_tx_thresh_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .wr_en(wr_en),
    .wr_data(wr_data), .wr_eop(wr_eop), .fill_space(fill_space),
    .drain_tick(drain_tick), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_eop(tx_eop), .tx_abort(tx_abort)
  );

  // drain tick every other cycle
  initial begin
    drain_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1 drain_tick = ~drain_tick;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (first_wr < 0) first_wr = wr_cnt;
        if (!last_tick) tick_err = tick_err + 1;
        if (rx_n < 64) begin
          rx_data[rx_n] = tx_data;
          rx_eop[rx_n]  = tx_eop;
        end
        rx_n = rx_n + 1;
      end
      if (tx_abort) abort_n = abort_n + 1;
    end
    last_tick = drain_tick;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input int pkt, input int idx);
    return {40'd0, 8'(pkt), 16'(idx)};
  endfunction

  task automatic put(input logic [DATA_W-1:0] d, input logic e);
    @(posedge clk);
    #1;
    wr_en = 1'b1; wr_data = d; wr_eop = e;
    wr_cnt = wr_cnt + 1;
  endtask

  task automatic idle_wr();
    @(posedge clk);
    #1 wr_en = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic clear_rx();
    rx_n = 0; abort_n = 0; first_wr = -1; wr_cnt = 0; tick_err = 0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_thresh = '0; wr_en = 1'b0; wr_data = '0; wr_eop = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    // R1: reset state
    check("R1 tx_valid", 64'(tx_valid), 64'd0);
    check("R1 tx_abort", 64'(tx_abort), 64'd0);
    check("R1 fill_space", 64'(fill_space), 64'd32);

    for (int r = 0; r < ROWS; r++) begin
      int thr, len, burst, exp_ab, exp_n, thr_eff, need;
      thr = TBL[r][0]; len = TBL[r][1]; burst = TBL[r][2]; exp_ab = TBL[r][3];
      thr_eff = (thr == 0) ? 1 : thr;
      need = (thr_eff < len) ? thr_eff : len;
      exp_n = exp_ab ? burst : len;
      clear_rx();
      cfg_thresh = CNT_W'(thr);
      for (int i = 0; i < burst; i++) put(word_of(r, i), i == len - 1);
      idle_wr();
      if (burst < len) begin
        repeat (60) @(posedge clk);
        for (int i = burst; i < len; i++) put(word_of(r, i), i == len - 1);
        idle_wr();
      end
      repeat (90) @(posedge clk);
      #5;
      // R2/R3: start not before threshold (or whole short packet) written
      check("R2 R3 start gate", 64'(first_wr >= need), 64'd1);
      // R4/R5: word count, order, end marker
      check("R4 R5 word count", 64'(rx_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < 64; i++) begin
        check("R4 data order", rx_data[i], word_of(r, i));
        check("R4 eop flag", 64'(rx_eop[i]), 64'(!exp_ab && i == len - 1));
      end
      check("R4 tick timing", 64'(tick_err), 64'd0);
      // R7/R8: abort count, flushed remainder
      check("R7 R8 abort count", 64'(abort_n), 64'(exp_ab));
      check("R8 store drained", 64'(fill_space), 64'd32);
    end

    // R9/R6: threshold above depth, overfilled store without end marker
    clear_rx();
    cfg_thresh = CNT_W'(40);
    for (int i = 0; i < 34; i++) put(word_of(9, i), 1'b0);
    idle_wr();
    repeat (10) @(posedge clk);
    #5;
    check("R9 no start above depth", 64'(rx_n), 64'd0);
    check("R6 full space zero", 64'(fill_space), 64'd0);
    cfg_thresh = CNT_W'(1);
    repeat (100) @(posedge clk);
    #5;
    check("R6 extra writes dropped", 64'(rx_n), 64'd32);
    check("R6 last kept word", rx_data[31], word_of(9, 31));
    check("R7 underflow abort", 64'(abort_n), 64'd1);
    // R8: end-marker word is discarded by the flush
    put(word_of(9, 99), 1'b1);
    idle_wr();
    repeat (10) @(posedge clk);
    #5;
    check("R8 flush no output", 64'(rx_n), 64'd32);
    check("R8 flush drained", 64'(fill_space), 64'd32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule